// File: doc/BRIEF.md
# CAN Controller Host Status and Interrupt Register Block

This block holds the host-visible control state of a CAN controller running in its extended register layout. A byte-wide bus reads and writes the mode word, the command strobe, the status byte, the pending-interrupt byte and the interrupt-enable mask. Command writes become single-cycle pulses toward the transmit engine and the receive FIFO. Those neighbours report back through event inputs. The block folds each report into the status and interrupt bytes and drives a level interrupt line.

The receive FIFO supplies a level that stays high while at least one stored message waits. Reading the interrupt byte returns it and clears it in the same access. The receive bit is set again at once if that level is still high, so a host that drains the interrupt byte cannot lose a waiting message. A synchronous hardware reset and a separate software-reset request load different values.

Top module: `can_host_regs`

## Requirements
- R1: After hardware reset (`rst` high at a clock edge), mode (address 0) reads 0x01, status (address 2) reads 0x3C, the interrupt byte (address 3) reads 0x00, the enable mask (address 4) reads 0x00, and `irq_o` is low.
- R2: A write to address 0 stores only `bus_wdata[4:0]`, and bits 7..5 read as zero. `rx_flush` pulses high for one cycle after a write that takes mode bit 0 from 1 to 0. No other mode write pulses it.
- R3: Address 1 (command) always reads 0x00. Writes to address 2 (status) and address 3 (interrupt byte) change nothing. Any address not listed here reads 0x00.
- R4: Writing address 1 with bit 0 set pulses `tx_req` for one cycle and clears status bits 3 and 2. An `ev_tx_done` pulse sets status bits 3 and 2, clears status bit 5 and sets interrupt bit 1.
- R5: Writing address 1 with bit 2 set pulses `rel_req` for one cycle only if `msg_pending` is high in the write cycle.
- R6: Writing address 1 with bit 3 set pulses `ovr_clr` and clears status bit 1 and interrupt bit 3.
- R7: `ev_rx_start` sets status bit 4. `ev_rx_reject` clears status bit 4. `ev_rx_stored` clears status bit 4 and sets status bit 0 and interrupt bit 0. `ev_overrun` clears status bit 4 and sets status bit 1 and interrupt bit 3. Each takes effect at the clock edge that samples it.
- R8: A read of address 3 returns the current interrupt byte. After that edge the interrupt byte equals `msg_pending` in bit 0 and zero elsewhere, before any sets from the same cycle are applied.
- R9: `irq_o` is high exactly when some bit is set in both the enable mask and the interrupt byte.
- R10: A `soft_rst` pulse clears mode bits 5, 4 and 0 and then sets mode bit 0. It clears status bits 5, 4, 2, 1 and 0 and then sets bits 5, 4 and 2. Status updates and mode writes in that cycle are ignored, and the interrupt byte is not affected.
- R11: A write to address 16 (first transmit-buffer byte) sets status bit 5 when mode bit 0 is 0, and leaves status unchanged when mode bit 0 is 1.
- R12: When `msg_pending` falls from 1 to 0, status bit 0 and interrupt bit 0 are cleared at that edge.
- R13: When a set and a clear of the same status or interrupt bit arrive in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (applies read side effects) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| soft_rst | input | 1 | Software-reset request pulse |
| ev_rx_start | input | 1 | Incoming frame processing began |
| ev_rx_stored | input | 1 | Incoming frame stored in FIFO |
| ev_rx_reject | input | 1 | Incoming frame rejected |
| ev_overrun | input | 1 | Incoming frame lost, FIFO full |
| ev_tx_done | input | 1 | Transmission finished |
| msg_pending | input | 1 | FIFO holds at least one message |
| tx_req | output | 1 | Transmit request pulse |
| rel_req | output | 1 | Release receive buffer pulse |
| ovr_clr | output | 1 | Clear overrun pulse |
| rx_flush | output | 1 | Flush receive FIFO pulse on leaving reset mode |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle, and that `msg_pending` is a level driven by the FIFO rather than a pulse. The R10 property also assumes that the receive-event inputs carry no meaning while a software reset is applied. The random stimulus only ever picks one bus operation per cycle and moves `msg_pending` as a slowly toggling level. Event pulses may still collide with each other and with command writes, which exercises the set-over-clear order of R13.

// File: rtl/can_host_pkg.sv
package can_host_pkg;

    typedef logic [7:0] byte_t;

    // register addresses (the transmit-buffer base is decoded by the neighbour)
    localparam int A_MODE = 0;
    localparam int A_CMD  = 1;
    localparam int A_STAT = 2;
    localparam int A_IRQ  = 3;
    localparam int A_IEN  = 4;
    localparam int A_TXB0 = 16;

    // status bit positions
    localparam int ST_RXFULL = 0;
    localparam int ST_OVR    = 1;
    localparam int ST_TXBUF  = 2;
    localparam int ST_TXDONE = 3;
    localparam int ST_RXING  = 4;
    localparam int ST_TXING  = 5;

    // interrupt bit positions
    localparam int IR_RX  = 0;
    localparam int IR_TX  = 1;
    localparam int IR_OVR = 3;

    // command bit positions
    localparam int CM_TX  = 0;
    localparam int CM_REL = 2;
    localparam int CM_CLO = 3;

    localparam byte_t MODE_HW     = 8'h01;
    localparam byte_t STAT_HW     = 8'h3C;
    localparam byte_t MODE_WMASK  = 8'h1F;
    localparam byte_t MODE_SW_CLR = 8'h31;
    localparam byte_t STAT_SW_CLR = 8'h37;
    localparam byte_t STAT_SW_SET = 8'h34;

    typedef struct packed {
        logic tx;
        logic rel;
        logic clr_ovr;
    } cmd_t;

    typedef struct packed {
        logic rx_start;
        logic rx_stored;
        logic rx_reject;
        logic overrun;
        logic tx_done;
        logic pend_fell;
    } ev_t;

    function automatic byte_t sw_mode(byte_t m);
        return (m & ~MODE_SW_CLR) | MODE_HW;
    endfunction

    function automatic byte_t sw_stat(byte_t s);
        return (s & ~STAT_SW_CLR) | STAT_SW_SET;
    endfunction

endpackage

// File: rtl/can_host_ctl.sv
module can_host_ctl
    import can_host_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  soft_rst,
    input  logic  wr_mode,
    input  logic  wr_ien,
    input  byte_t wdata,
    output byte_t mode_q,
    output byte_t ien_q,
    output logic  rx_flush
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_HW;
            ien_q    <= '0;
            rx_flush <= 1'b0;
        end else begin
            rx_flush <= wr_mode && !soft_rst && mode_q[0] && !wdata[0];
            if (soft_rst)
                mode_q <= sw_mode(mode_q);
            else if (wr_mode)
                mode_q <= wdata & MODE_WMASK;
            if (wr_ien)
                ien_q <= wdata;
        end
    end

    assert_flush_on_exit_R2: assert property (@(posedge clk) disable iff (rst)
        rx_flush |-> (!mode_q[0] && $past(mode_q[0])));

    assert_soft_mode_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> mode_q[0] && !mode_q[4] && !mode_q[5]);
endmodule

// File: rtl/can_host_cmd.sv
module can_host_cmd
    import can_host_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic msg_pending,
    output logic tx_req,
    output logic rel_req,
    output logic ovr_clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_req  <= 1'b0;
            rel_req <= 1'b0;
            ovr_clr <= 1'b0;
        end else begin
            tx_req  <= cmd.tx;
            rel_req <= cmd.rel && msg_pending;
            ovr_clr <= cmd.clr_ovr;
        end
    end

    assert_release_needs_msg_R5: assert property (@(posedge clk) disable iff (rst)
        rel_req |-> $past(msg_pending));

    assert_tx_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        cmd.tx |=> tx_req);
endmodule

// File: rtl/can_host_status.sv
module can_host_status
    import can_host_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  soft_rst,
    input  ev_t   ev,
    input  logic  cmd_tx,
    input  logic  cmd_clr_ovr,
    input  logic  txb_wr,
    output byte_t stat_q
);
    byte_t stat_d;

    always_comb begin
        stat_d = stat_q;
        if (soft_rst) begin
            stat_d = sw_stat(stat_q);
        end else begin
            // clears first, sets afterwards so a set wins
            if (cmd_tx) begin
                stat_d[ST_TXDONE] = 1'b0;
                stat_d[ST_TXBUF]  = 1'b0;
            end
            if (cmd_clr_ovr)  stat_d[ST_OVR]    = 1'b0;
            if (ev.pend_fell) stat_d[ST_RXFULL] = 1'b0;
            if (ev.rx_stored || ev.rx_reject || ev.overrun)
                stat_d[ST_RXING] = 1'b0;
            if (ev.tx_done) begin
                stat_d[ST_TXDONE] = 1'b1;
                stat_d[ST_TXBUF]  = 1'b1;
                stat_d[ST_TXING]  = 1'b0;
            end
            if (txb_wr)       stat_d[ST_TXING]  = 1'b1;
            if (ev.rx_start)  stat_d[ST_RXING]  = 1'b1;
            if (ev.rx_stored) stat_d[ST_RXFULL] = 1'b1;
            if (ev.overrun)   stat_d[ST_OVR]    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= STAT_HW;
        else     stat_q <= stat_d;
    end

    assert_soft_status_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (stat_q[ST_TXING] && stat_q[ST_RXING] && stat_q[ST_TXBUF]
                      && !stat_q[ST_OVR] && !stat_q[ST_RXFULL]));

    assert_overrun_wins_R13: assert property (@(posedge clk) disable iff (rst)
        (ev.overrun && !soft_rst) |=> stat_q[ST_OVR]);

    assert_stored_sets_full_R7: assert property (@(posedge clk) disable iff (rst)
        (ev.rx_stored && !soft_rst) |=> stat_q[ST_RXFULL]);
endmodule

// File: rtl/can_host_irq.sv
module can_host_irq
    import can_host_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_clr,
    input  logic  msg_pending,
    input  logic  pend_fell,
    input  logic  set_rx,
    input  logic  set_tx,
    input  logic  set_ovr,
    input  logic  clr_ovr,
    output byte_t irq_q
);
    byte_t irq_d;

    always_comb begin
        irq_d = irq_q;
        if (rd_clr) begin
            irq_d        = '0;
            irq_d[IR_RX] = msg_pending;
        end
        if (clr_ovr)   irq_d[IR_OVR] = 1'b0;
        if (pend_fell) irq_d[IR_RX]  = 1'b0;
        if (set_rx)    irq_d[IR_RX]  = 1'b1;
        if (set_tx)    irq_d[IR_TX]  = 1'b1;
        if (set_ovr)   irq_d[IR_OVR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_d;
    end

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !msg_pending && !set_rx && !set_tx && !set_ovr) |=> (irq_q == 8'h00));

    assert_read_rearms_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && msg_pending) |=> irq_q[IR_RX]);

    assert_pend_fall_R12: assert property (@(posedge clk) disable iff (rst)
        (pend_fell && !set_rx) |=> !irq_q[IR_RX]);
endmodule

// File: rtl/can_host_regs.sv
module can_host_regs
    import can_host_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              soft_rst,
    input  logic              ev_rx_start,
    input  logic              ev_rx_stored,
    input  logic              ev_rx_reject,
    input  logic              ev_overrun,
    input  logic              ev_tx_done,
    input  logic              msg_pending,
    output logic              tx_req,
    output logic              rel_req,
    output logic              ovr_clr,
    output logic              rx_flush,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_MODE);
    localparam logic [ADDR_W-1:0] AD_CMD  = ADDR_W'(A_CMD);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_IRQ  = ADDR_W'(A_IRQ);
    localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] AD_TXB0 = ADDR_W'(A_TXB0);

    byte_t mode_q, ien_q, stat_q, irq_q;
    logic  pend_q;
    cmd_t  cmd;
    ev_t   ev;
    logic  wr_cmd, txb_wr, rd_clr;

    assign wr_cmd      = bus_wr && (bus_addr == AD_CMD);
    assign cmd.tx      = wr_cmd && bus_wdata[CM_TX];
    assign cmd.rel     = wr_cmd && bus_wdata[CM_REL];
    assign cmd.clr_ovr = wr_cmd && bus_wdata[CM_CLO];
    assign txb_wr      = bus_wr && (bus_addr == AD_TXB0) && !mode_q[0];
    assign rd_clr      = bus_rd && (bus_addr == AD_IRQ);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= msg_pending;
    end

    assign ev.rx_start  = ev_rx_start;
    assign ev.rx_stored = ev_rx_stored;
    assign ev.rx_reject = ev_rx_reject;
    assign ev.overrun   = ev_overrun;
    assign ev.tx_done   = ev_tx_done;
    assign ev.pend_fell = pend_q && !msg_pending;

    can_host_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_mode  (bus_wr && (bus_addr == AD_MODE)),
        .wr_ien   (bus_wr && (bus_addr == AD_IEN)),
        .wdata    (bus_wdata),
        .mode_q   (mode_q),
        .ien_q    (ien_q),
        .rx_flush (rx_flush)
    );

    can_host_cmd u_cmd (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .msg_pending (msg_pending),
        .tx_req      (tx_req),
        .rel_req     (rel_req),
        .ovr_clr     (ovr_clr)
    );

    can_host_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .soft_rst    (soft_rst),
        .ev          (ev),
        .cmd_tx      (cmd.tx),
        .cmd_clr_ovr (cmd.clr_ovr),
        .txb_wr      (txb_wr),
        .stat_q      (stat_q)
    );

    can_host_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .rd_clr      (rd_clr),
        .msg_pending (msg_pending),
        .pend_fell   (ev.pend_fell),
        .set_rx      (ev_rx_stored),
        .set_tx      (ev_tx_done),
        .set_ovr     (ev_overrun),
        .clr_ovr     (cmd.clr_ovr),
        .irq_q       (irq_q)
    );

    always_comb begin
        case (bus_addr)
            AD_MODE: bus_rdata = mode_q;
            AD_STAT: bus_rdata = stat_q;
            AD_IRQ:  bus_rdata = irq_q;
            AD_IEN:  bus_rdata = ien_q;
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq_o = |(ien_q & irq_q);

    assert_status_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AD_STAT && !soft_rst && !ev_rx_start && !ev_rx_stored
         && !ev_rx_reject && !ev_overrun && !ev_tx_done && !ev.pend_fell) |=> $stable(stat_q));

    assert_txb_reset_mode_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AD_TXB0 && mode_q[0] && !stat_q[ST_TXING] && !soft_rst)
        |=> !stat_q[ST_TXING]);
endmodule

// File: tb/tb_can_host_regs.sv
module tb_can_host_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 0, bus_rd = 0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       soft_rst = 0, ev_rx_start = 0, ev_rx_stored = 0, ev_rx_reject = 0;
    logic       ev_overrun = 0, ev_tx_done = 0, msg_pending = 0;
    logic       tx_req, rel_req, ovr_clr, rx_flush, irq_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_mode, m_stat, m_irq, m_ier;
    logic       m_pq;
    logic       e_tx, e_rel, e_ovc, e_fl;

    always #5 clk = ~clk;

    can_host_regs #(.ADDR_W(5)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .soft_rst(soft_rst),
        .ev_rx_start(ev_rx_start), .ev_rx_stored(ev_rx_stored), .ev_rx_reject(ev_rx_reject),
        .ev_overrun(ev_overrun), .ev_tx_done(ev_tx_done), .msg_pending(msg_pending),
        .tx_req(tx_req), .rel_req(rel_req), .ovr_clr(ovr_clr), .rx_flush(rx_flush), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mread(input logic [4:0] a);
        case (a)
            5'd0: return m_mode;
            5'd2: return m_stat;
            5'd3: return m_irq;
            5'd4: return m_ier;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rtag(input logic [4:0] a);
        case (a)
            5'd0: return "R2 mode read";
            5'd2: return "R7 status read";
            5'd3: return "R8 irq read";
            5'd4: return "R9 enable read";
            default: return "R3 other read";
        endcase
    endfunction

    task automatic hw_model_reset();
        m_mode = 8'h01; m_stat = 8'h3C; m_irq = 8'h00; m_ier = 8'h00; m_pq = 1'b0;
        e_tx = 0; e_rel = 0; e_ovc = 0; e_fl = 0;
    endtask

    // reference update built from the requirements
    task automatic model_step();
        logic wm, wc, fell, txb;
        logic [7:0] ns, ni, nm;
        wm   = bus_wr && bus_addr == 5'd0;
        wc   = bus_wr && bus_addr == 5'd1;
        fell = m_pq && !msg_pending;
        txb  = bus_wr && bus_addr == 5'd16 && !m_mode[0];
        e_tx  = wc && bus_wdata[0];
        e_rel = wc && bus_wdata[2] && msg_pending;
        e_ovc = wc && bus_wdata[3];
        e_fl  = wm && m_mode[0] && !bus_wdata[0] && !soft_rst;
        nm = m_mode;
        if (soft_rst) nm = (m_mode & 8'hCE) | 8'h01;
        else if (wm)  nm = bus_wdata & 8'h1F;
        ns = m_stat;
        if (soft_rst) ns = (m_stat & 8'hC8) | 8'h34;
        else begin
            if (e_tx) ns[3:2] = 2'b00;
            if (e_ovc) ns[1] = 1'b0;
            if (fell) ns[0] = 1'b0;
            if (ev_rx_stored || ev_rx_reject || ev_overrun) ns[4] = 1'b0;
            if (ev_tx_done) begin ns[3:2] = 2'b11; ns[5] = 1'b0; end
            if (txb) ns[5] = 1'b1;
            if (ev_rx_start) ns[4] = 1'b1;
            if (ev_rx_stored) ns[0] = 1'b1;
            if (ev_overrun) ns[1] = 1'b1;
        end
        ni = m_irq;
        if (bus_rd && bus_addr == 5'd3) ni = {7'b0, msg_pending};
        if (e_ovc) ni[3] = 1'b0;
        if (fell) ni[0] = 1'b0;
        if (ev_rx_stored) ni[0] = 1'b1;
        if (ev_tx_done) ni[1] = 1'b1;
        if (ev_overrun) ni[3] = 1'b1;
        if (bus_wr && bus_addr == 5'd4) m_ier = bus_wdata;
        m_mode = nm; m_stat = ns; m_irq = ni; m_pq = msg_pending;
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; soft_rst = 0; ev_rx_start = 0; ev_rx_stored = 0;
        ev_rx_reject = 0; ev_overrun = 0; ev_tx_done = 0;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        idle();
        chk("R9 irq_o level", {7'b0, irq_o}, {7'b0, |(m_ier & m_irq)});
        chk("R4 tx_req pulse", {7'b0, tx_req}, {7'b0, e_tx});
        chk("R5 rel_req pulse", {7'b0, rel_req}, {7'b0, e_rel});
        chk("R6 ovr_clr pulse", {7'b0, ovr_clr}, {7'b0, e_ovc});
        chk("R2 rx_flush pulse", {7'b0, rx_flush}, {7'b0, e_fl});
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        bus_rd = 1; bus_addr = a;
        #1;
        chk(tag, bus_rdata, mread(a));
        tick();
    endtask

    task automatic ev_tick(input logic [2:0] which);
        case (which)
            3'd0: ev_rx_start = 1;
            3'd1: ev_rx_stored = 1;
            3'd2: ev_rx_reject = 1;
            3'd3: ev_overrun = 1;
            3'd4: ev_tx_done = 1;
            default: soft_rst = 1;
        endcase
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        hw_model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values, checked against fixed constants
        #1;
        bus_addr = 5'd0; #1; chk("R1 mode reset", bus_rdata, 8'h01);
        bus_addr = 5'd2; #1; chk("R1 status reset", bus_rdata, 8'h3C);
        bus_addr = 5'd3; #1; chk("R1 irq reset", bus_rdata, 8'h00);
        bus_addr = 5'd4; #1; chk("R1 enable reset", bus_rdata, 8'h00);
        chk("R1 irq_o reset", {7'b0, irq_o}, 8'h00);
        @(negedge clk);

        // R3 ignored writes and zero reads
        wr(5'd2, 8'hFF); rd(5'd2, "R3 status write ignored");
        wr(5'd3, 8'hFF); rd(5'd3, "R3 irq write ignored");
        rd(5'd1, "R3 command reads zero");
        rd(5'd9, "R3 unmapped reads zero");

        // R2 mode masking and flush pulse
        wr(5'd0, 8'hFF);
        bus_addr = 5'd0; #1; chk("R2 mode masked", bus_rdata, 8'h1F);
        wr(5'd0, 8'h00);           // 1 -> 0: flush pulse checked in tick
        wr(5'd0, 8'h00);           // 0 -> 0: no flush
        rd(5'd0, "R2 mode operating");

        // R4 transmit sequence
        wr(5'd1, 8'h01); rd(5'd2, "R4 status after tx request");
        ev_tick(3'd4);   rd(5'd2, "R4 status after tx done");
        rd(5'd3, "R4 irq tx bit"); rd(5'd3, "R8 irq cleared");

        // R11 transmit buffer writes
        wr(5'd16, 8'h5A); rd(5'd2, "R11 op mode sets bit5");
        wr(5'd0, 8'h01); ev_tick(3'd4); wr(5'd16, 8'h5A);
        rd(5'd2, "R11 reset mode no effect");
        wr(5'd0, 8'h00);

        // R9 enable mask
        wr(5'd4, 8'h02); ev_tick(3'd4);
        chk("R9 irq_o enabled", {7'b0, irq_o}, 8'h01);
        wr(5'd4, 8'h01); chk("R9 irq_o masked", {7'b0, irq_o}, 8'h00);
        wr(5'd4, 8'hFF); rd(5'd3, "R8 read clears tx bit");

        // R7 receive events, R8 rearm
        ev_tick(3'd2); rd(5'd2, "R7 reject clears bit4");
        ev_tick(3'd0); rd(5'd2, "R7 start sets bit4");
        msg_pending = 1; ev_tick(3'd1); rd(5'd2, "R7 stored status");
        rd(5'd3, "R8 irq rx"); rd(5'd3, "R8 rx rearmed");
        ev_tick(3'd3); rd(5'd2, "R7 overrun status");

        // R6 clear overrun
        wr(5'd1, 8'h08); rd(5'd2, "R6 overrun cleared"); rd(5'd3, "R6 irq bit3 cleared");

        // R5 release and R12 pending fall
        wr(5'd1, 8'h04);
        msg_pending = 0; tick(); rd(5'd2, "R12 status bit0 cleared"); rd(5'd3, "R12 irq bit0");
        wr(5'd1, 8'h04);

        // R13 set wins over clear
        bus_wr = 1; bus_addr = 5'd1; bus_wdata = 8'h08; ev_overrun = 1; tick();
        rd(5'd2, "R13 overrun kept");

        // R10 software reset
        wr(5'd0, 8'h1E); wr(5'd1, 8'h01);
        ev_tick(3'd5);
        bus_addr = 5'd0; #1; chk("R10 soft mode", bus_rdata, 8'h0F);
        bus_addr = 5'd2; #1; chk("R10 soft status", bus_rdata, m_stat);
        rd(5'd3, "R10 irq untouched");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [4:0] a;
            op = $urandom % 10;
            case ($urandom % 7)
                0: a = 5'd0; 1: a = 5'd1; 2: a = 5'd2; 3: a = 5'd3;
                4: a = 5'd4; 5: a = 5'd16; default: a = 5'($urandom);
            endcase
            v = 8'($urandom);
            if (($urandom % 10) == 0) msg_pending = !msg_pending;
            ev_rx_start  = ($urandom % 8) == 0;
            ev_rx_stored = ($urandom % 8) == 0;
            ev_rx_reject = ($urandom % 10) == 0;
            ev_overrun   = ($urandom % 12) == 0;
            ev_tx_done   = ($urandom % 8) == 0;
            soft_rst     = ($urandom % 60) == 0;
            if (op < 3) begin
                bus_wr = 1; bus_addr = a; bus_wdata = v;
                tick();
            end else if (op < 6) begin
                rd(a, rtag(a));
            end else begin
                tick();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule